// File: doc/BRIEF.md
# Delay-Tolerant Gadget Chain Detector

This block watches the retirement stream of a processor core. Each retired instruction arrives with a three-bit class code. The block looks for the signature of a code-reuse attack: a sequence of short instruction runs, each ending in a control transfer, that follow one another without a break. Two small counters make up the detector state. One counts the instructions since the last transfer. The other counts the short runs, or gadgets, seen in a row. When the gadget count reaches three, a sticky alarm is raised.

An attacker can pad a chain with calls to harmless functions so that the gadgets appear to be far apart. To catch this, the detector keeps a private hardware stack. A direct call saves the detector state and starts the callee from zero. The matching return puts the saved state back. A harmless callee therefore acts as a delay that leaves the chain unbroken. A callee whose own body forms a chain raises the alarm by itself. An indirect jump writes its updated state into the top saved entry, so progress made inside a callee survives the return. Only one push or pop is allowed in each commit window of `WIN_LEN` cycles. The stack has a fixed depth and reports overflow with a sticky flag.

Top module: `gadget_chain_detector`

## Requirements
- R1: The class codes are 0 other, 1 indirect jump, 2 indirect call, 3 direct call, 4 return. A transfer (code 1, 2, or a return that counts as a transfer) ends a gadget when at most 4 other instructions came before it since the last transfer. Such a transfer adds one to the consecutive-gadget count, which saturates at 3. Every transfer restarts the instruction count at zero.
- R2: The transfer that brings the consecutive-gadget count to 3 sets `attack_alarm` at the next clock edge. An indirect call counts as a transfer for this purpose.
- R3: A transfer that follows 5 or more other instructions resets the consecutive-gadget count to zero. The instruction count saturates at 6.
- R4: A granted direct call saves the current state and restarts the state at zero. A granted return with a non-empty stack restores the saved state exactly and does not count as a transfer.
- R5: A callee whose own body contains three consecutive gadgets raises the alarm, whatever state its caller saved.
- R6: An indirect jump with a non-empty stack overwrites the top saved entry with the state that follows the jump.
- R7: A return that finds the stack empty counts as a transfer on the current state.
- R8: Windows of `WIN_LEN` cycles (default 4) follow one another. The first window starts at the first cycle after reset. Each window grants at most one push or pop. A direct call that is refused counts as an other instruction. A return that is refused counts as a transfer.
- R9: The stack holds `DEPTH` entries (default 16). A push onto a full stack overwrites the oldest entry and sets `stack_overflow`, which stays high until reset.
- R10: `attack_alarm` stays high until `alarm_clear` is high at a clock edge. If a detection happens in the same cycle as a clear, the detection wins.
- R11: After reset, both outputs are low, the state is zero and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit_valid | input | 1 | An instruction retires this cycle |
| commit_class | input | 3 | Class code of the retiring instruction |
| alarm_clear | input | 1 | Synchronous clear of the alarm |
| attack_alarm | output | 1 | Sticky attack detection |
| stack_overflow | output | 1 | Sticky stack overflow status |

## Verification
The main stimulus uses runs of ordinary instructions of different lengths, each ending in a transfer. Runs of four and five others show where the gadget limit lies, and a run of six shows where the count saturates. Three padding patterns are tried: a harmless delay callee, a malicious callee, and a callee whose indirect jumps carry progress back. Each one separates a working save/restore path from one that is missing or stale. Directed sequences place several calls and returns inside one commit window to show the throttling. They also push one entry past full and then unwind, which shows whether the oldest entry or the newest is discarded.

// File: rtl/chain_pkg.sv
package chain_pkg;

    localparam int ICNT_W    = 3;
    localparam int GCNT_W    = 2;
    localparam int RUN_MAX   = 5;            // longest gadget, transfer included
    localparam int ICNT_SAT  = RUN_MAX + 1;
    localparam int CHAIN_MIN = 3;

    typedef enum logic [2:0] {
        CLS_OTHER = 3'd0,
        CLS_IJMP  = 3'd1,
        CLS_ICALL = 3'd2,
        CLS_DCALL = 3'd3,
        CLS_RET   = 3'd4
    } insn_cls_e;

    typedef struct packed {
        logic [ICNT_W-1:0] icnt;
        logic [GCNT_W-1:0] gcnt;
    } fsm_state_t;

    localparam logic [ICNT_W-1:0] ICNT_TOP  = ICNT_W'(ICNT_SAT);
    localparam logic [ICNT_W-1:0] ICNT_LIM  = ICNT_W'(RUN_MAX);
    localparam logic [GCNT_W-1:0] GCNT_TOP  = '1;
    localparam logic [GCNT_W-1:0] GCNT_HIT  = GCNT_W'(CHAIN_MIN);

    // non-transfer instruction: extend the current run
    function automatic fsm_state_t step_plain(input fsm_state_t s);
        fsm_state_t r;
        r = s;
        if (s.icnt != ICNT_TOP) r.icnt = s.icnt + 1'b1;
        return r;
    endfunction

    // transfer: close the run, judge it, start a fresh run
    function automatic fsm_state_t step_transfer(input fsm_state_t s);
        fsm_state_t r;
        r.icnt = '0;
        if (s.icnt < ICNT_LIM)
            r.gcnt = (s.gcnt == GCNT_TOP) ? s.gcnt : s.gcnt + 1'b1;
        else
            r.gcnt = '0;
        return r;
    endfunction

endpackage

// File: rtl/commit_throttle.sv
module commit_throttle #(
    parameter int WIN_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic op_taken,
    output logic op_avail
);
    localparam int WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [WW-1:0] LAST = WW'(WIN_LEN - 1);

    logic [WW-1:0] win_cnt;
    logic          op_used;

    assign op_avail = !op_used;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
            op_used <= 1'b0;
        end else if (win_cnt == LAST) begin
            win_cnt <= '0;
            op_used <= 1'b0;
        end else begin
            win_cnt <= win_cnt + 1'b1;
            op_used <= op_used | op_taken;
        end
    end
endmodule

// File: rtl/secure_stack.sv
module secure_stack
    import chain_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             wr_top,
    input  fsm_state_t       push_data,
    input  fsm_state_t       top_wdata,
    output fsm_state_t       top_data,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    fsm_state_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] top_ptr;

    assign top_ptr  = wr_ptr - 1'b1;
    assign top_data = mem[top_ptr];
    assign empty    = (count == '0);
    assign full     = (count == FULL_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (push) begin
            mem[wr_ptr] <= push_data;      // circular: full push overwrites oldest
            wr_ptr      <= wr_ptr + 1'b1;
            if (!full) count <= count + 1'b1;
        end else if (pop && !empty) begin
            wr_ptr <= top_ptr;
            count  <= count - 1'b1;
        end else if (wr_top && !empty) begin
            mem[top_ptr] <= top_wdata;
        end
    end
endmodule

// File: rtl/chain_step.sv
module chain_step
    import chain_pkg::*;
(
    input  logic       valid,
    input  insn_cls_e  cls,
    input  fsm_state_t cur,
    input  fsm_state_t top,
    input  logic       empty,
    input  logic       avail,
    output fsm_state_t nxt,
    output logic       push,
    output logic       pop,
    output logic       wr_top,
    output logic       hit
);
    logic xfer;

    always_comb begin
        nxt    = cur;
        push   = 1'b0;
        pop    = 1'b0;
        wr_top = 1'b0;
        xfer   = 1'b0;
        if (valid) begin
            unique case (cls)
                CLS_IJMP: begin
                    xfer   = 1'b1;
                    wr_top = !empty;
                end
                CLS_ICALL: xfer = 1'b1;
                CLS_DCALL: begin
                    if (avail) begin
                        push = 1'b1;
                        nxt  = '0;
                    end else begin
                        nxt = step_plain(cur);
                    end
                end
                CLS_RET: begin
                    if (avail && !empty) begin
                        pop = 1'b1;
                        nxt = top;
                    end else begin
                        xfer = 1'b1;
                    end
                end
                default: nxt = step_plain(cur);
            endcase
            if (xfer) nxt = step_transfer(cur);
        end
        hit = xfer && (nxt.gcnt >= GCNT_HIT);
    end
endmodule

// File: rtl/gadget_chain_detector.sv
module gadget_chain_detector
    import chain_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int WIN_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       commit_valid,
    input  logic [2:0] commit_class,
    input  logic       alarm_clear,
    output logic       attack_alarm,
    output logic       stack_overflow
);
    localparam int AW = $clog2(DEPTH);

    fsm_state_t    cur_state, nxt_state, top_state;
    logic          push, pop, wr_top, hit, empty, full, avail;
    logic [AW:0]   depth_cnt;
    insn_cls_e     cls;

    assign cls = insn_cls_e'(commit_class);

    commit_throttle #(.WIN_LEN(WIN_LEN)) u_win (
        .clk      (clk),
        .rst      (rst),
        .op_taken (push | pop),
        .op_avail (avail)
    );

    chain_step u_step (
        .valid  (commit_valid),
        .cls    (cls),
        .cur    (cur_state),
        .top    (top_state),
        .empty  (empty),
        .avail  (avail),
        .nxt    (nxt_state),
        .push   (push),
        .pop    (pop),
        .wr_top (wr_top),
        .hit    (hit)
    );

    secure_stack #(.DEPTH(DEPTH)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .wr_top    (wr_top),
        .push_data (cur_state),
        .top_wdata (nxt_state),
        .top_data  (top_state),
        .empty     (empty),
        .full      (full),
        .count     (depth_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state      <= '0;
            attack_alarm   <= 1'b0;
            stack_overflow <= 1'b0;
        end else begin
            cur_state <= nxt_state;
            if (hit)              attack_alarm <= 1'b1;
            else if (alarm_clear) attack_alarm <= 1'b0;
            if (push && full)     stack_overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/chain_checker.sv
module chain_checker #(
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   commit_valid,
    input logic [2:0]             commit_class,
    input logic                   alarm_clear,
    input logic                   attack_alarm,
    input logic                   stack_overflow,
    input logic                   hit,
    input logic                   push,
    input logic                   pop,
    input logic                   avail,
    input logic [$clog2(DEPTH):0] depth_cnt
);
    AST_ALARM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        attack_alarm && !alarm_clear |=> attack_alarm); // R10
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        alarm_clear && !hit |=> !attack_alarm); // R10
    AST_ALARM_FROM_TRANSFER: assert property (@(posedge clk) disable iff (rst)
        $rose(attack_alarm) |-> $past(commit_valid && (commit_class == 3'd1 ||
            commit_class == 3'd2 || commit_class == 3'd4))); // R2
    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (rst)
        stack_overflow |=> stack_overflow); // R9
    AST_OVERFLOW_ON_CALL: assert property (@(posedge clk) disable iff (rst)
        $rose(stack_overflow) |-> $past(commit_valid && commit_class == 3'd3)); // R9
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        depth_cnt <= ($clog2(DEPTH)+1)'(DEPTH)); // R9
    AST_ONE_OP_PER_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !avail |-> !(push || pop)); // R8
endmodule

bind gadget_chain_detector chain_checker #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .commit_valid   (commit_valid),
    .commit_class   (commit_class),
    .alarm_clear    (alarm_clear),
    .attack_alarm   (attack_alarm),
    .stack_overflow (stack_overflow),
    .hit            (hit),
    .push           (push),
    .pop            (pop),
    .avail          (avail),
    .depth_cnt      (depth_cnt)
);

// File: tb/sim_gadget_chain_detector.sv
module sim_gadget_chain_detector;

    localparam int DEPTH   = 16;
    localparam int WIN_LEN = 4;
    localparam logic [2:0] K_OTH = 3'd0, K_IJ = 3'd1, K_IC = 3'd2,
                           K_DC = 3'd3, K_RT = 3'd4;

    typedef struct packed {
        logic [2:0]  cls;
        logic        vld;
        logic        clr;
        logic        ea;
        logic        eo;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 56;
    localparam vec_t VECS [NV] = '{
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_IJ,  1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_IJ,  1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_IC,  1'b1, 1'b0, 1'b1, 1'b0, "R2"},
        '{K_OTH, 1'b0, 1'b1, 1'b0, 1'b0, "R10"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{K_IJ,  1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_IJ,  1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_IJ,  1'b1, 1'b0, 1'b0, 1'b0, "R1"},
        '{K_RT,  1'b1, 1'b0, 1'b1, 1'b0, "R7"},
        '{K_OTH, 1'b0, 1'b1, 1'b0, 1'b0, "R10"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{K_IJ,  1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{K_DC,  1'b1, 1'b0, 1'b0, 1'b0, "R6"},
        '{K_IJ,  1'b1, 1'b0, 1'b0, 1'b0, "R6"},
        '{K_IJ,  1'b1, 1'b0, 1'b0, 1'b0, "R6"},
        '{K_RT,  1'b1, 1'b0, 1'b0, 1'b0, "R6"},
        '{K_IJ,  1'b1, 1'b0, 1'b1, 1'b0, "R6"},
        '{K_OTH, 1'b0, 1'b1, 1'b0, 1'b0, "R10"},
        '{K_DC,  1'b1, 1'b0, 1'b0, 1'b0, "R4"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R4"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R4"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R4"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R4"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R4"},
        '{K_OTH, 1'b1, 1'b0, 1'b0, 1'b0, "R4"},
        '{K_RT,  1'b1, 1'b0, 1'b0, 1'b0, "R4"},
        '{K_IJ,  1'b1, 1'b0, 1'b1, 1'b0, "R4"},
        '{K_OTH, 1'b0, 1'b1, 1'b0, 1'b0, "R10"},
        '{K_DC,  1'b1, 1'b0, 1'b0, 1'b0, "R5"},
        '{K_IJ,  1'b1, 1'b0, 1'b0, 1'b0, "R5"},
        '{K_IJ,  1'b1, 1'b0, 1'b0, 1'b0, "R5"},
        '{K_IJ,  1'b1, 1'b0, 1'b1, 1'b0, "R5"},
        '{K_OTH, 1'b0, 1'b1, 1'b0, 1'b0, "R10"},
        '{K_RT,  1'b1, 1'b0, 1'b0, 1'b0, "R4"},
        '{K_RT,  1'b1, 1'b0, 1'b1, 1'b0, "R7"},
        '{K_OTH, 1'b0, 1'b1, 1'b0, 1'b0, "R10"}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       commit_valid = 1'b0;
    logic [2:0] commit_class = 3'd0;
    logic       alarm_clear = 1'b0;
    logic       attack_alarm, stack_overflow;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    gadget_chain_detector #(.DEPTH(DEPTH), .WIN_LEN(WIN_LEN)) u0 (
        .clk            (clk),
        .rst            (rst),
        .commit_valid   (commit_valid),
        .commit_class   (commit_class),
        .alarm_clear    (alarm_clear),
        .attack_alarm   (attack_alarm),
        .stack_overflow (stack_overflow)
    );

    task automatic chk(input logic [23:0] tag, input string what,
                       input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // drive one cycle at a falling edge, advance to the next falling edge
    task automatic cyc(input logic [2:0] c, input logic v, input logic cl);
        commit_class = c;
        commit_valid = v;
        alarm_clear  = cl;
        @(negedge clk);
        commit_valid = 1'b0;
        alarm_clear  = 1'b0;
    endtask

    // one instruction per commit window, so throttling never interferes
    task automatic win(input logic [2:0] c, input logic v, input logic cl);
        cyc(c, v, cl);
        for (int k = 1; k < WIN_LEN; k++) cyc(K_OTH, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) begin
            win(VECS[i].cls, VECS[i].vld, VECS[i].clr);
            chk(VECS[i].tag, $sformatf("vector %0d alarm", i), attack_alarm, VECS[i].ea);
            chk(VECS[i].tag, $sformatf("vector %0d overflow", i), stack_overflow, VECS[i].eo);
        end

        // R11: reset state, then a chain from the zero state
        do_reset();
        chk("R11", "alarm after reset", attack_alarm, 1'b0);
        chk("R11", "overflow after reset", stack_overflow, 1'b0);
        win(K_IJ, 1'b1, 1'b0);
        win(K_IJ, 1'b1, 1'b0);
        chk("R11", "two gadgets from zero", attack_alarm, 1'b0);
        win(K_IJ, 1'b1, 1'b0);
        chk("R11", "three gadgets from zero", attack_alarm, 1'b1);

        // R10: detection wins over a simultaneous clear
        do_reset();
        win(K_IJ, 1'b1, 1'b0);
        win(K_IJ, 1'b1, 1'b0);
        win(K_IJ, 1'b1, 1'b1);
        chk("R10", "hit with clear", attack_alarm, 1'b1);
        win(K_OTH, 1'b0, 1'b1);
        chk("R10", "clear alone", attack_alarm, 1'b0);

        // R8: call then three returns in one window; returns are refused
        do_reset();
        cyc(K_DC, 1'b1, 1'b0);
        cyc(K_RT, 1'b1, 1'b0);
        cyc(K_RT, 1'b1, 1'b0);
        cyc(K_RT, 1'b1, 1'b0);
        chk("R8", "refused returns act as transfers", attack_alarm, 1'b1);

        // R8/R9: two calls per window for 16 windows = 16 pushes
        do_reset();
        win(K_IJ, 1'b1, 1'b0);
        win(K_IJ, 1'b1, 1'b0);
        for (int w = 0; w < DEPTH; w++) begin
            cyc(K_DC, 1'b1, 1'b0);
            cyc(K_DC, 1'b1, 1'b0);
            for (int k = 2; k < WIN_LEN; k++) cyc(K_OTH, 1'b0, 1'b0);
        end
        chk("R8", "second call per window refused", stack_overflow, 1'b0);
        win(K_DC, 1'b1, 1'b0);
        chk("R9", "push onto full stack", stack_overflow, 1'b1);
        for (int r = 0; r <= DEPTH; r++) win(K_RT, 1'b1, 1'b0);
        chk("R9", "oldest entry dropped", attack_alarm, 1'b0);
        win(K_IJ, 1'b1, 1'b0);
        chk("R9", "chain after unwind", attack_alarm, 1'b0);
        chk("R9", "overflow sticky", stack_overflow, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule